// File: doc/BRIEF.md
# Level Interrupt Aggregator for Power-Management Events

This block gathers seven power-management event lines into a set of pending bits and presents one level-sensitive request to a parent interrupt controller. Software reaches the pending bits and their enables through a small register bus. The request stays high for as long as at least one enabled pending bit is set.

The pending register is ordinary read/write, not write-zero-to-clear. A bus write therefore sets or clears bits to exactly the value written. A hardware event and a software clear can reach the same bit together. When that happens the event wins, so a new event is never lost.

To help a handler that services sources from the top down, the block also drives a status: a valid flag and the index of the highest-numbered enabled pending source.

Top module: `pm_irq_aggregator`

## Requirements
- R1: While reset is held and just after it, the pending and enable registers read zero, `irqReq` is low, `topValid` is low and `topIdx` is 0.
- R2: A bus write to offset 0x50 loads bits 6:0 of the write data into the pending register, so a 1 sets a pending bit and a 0 clears it. A read of offset 0x50 returns the pending bits in 6:0.
- R3: A bus write to offset 0x54 loads bits 6:0 into the enable register. A read of offset 0x54 returns them in 6:0.
- R4: `irqReq` is high exactly when the bitwise AND of pending and enable is non-zero. An enable bit of 1 passes its source and an enable bit of 0 blocks it.
- R5: A high `evtIn[i]` sampled at a clock edge sets pending bit i. The bit stays set until a bus write clears it.
- R6: If `evtIn[i]` is high in the same cycle as a bus write to offset 0x50, pending bit i ends up set whatever was written to it. All other bits take the written value.
- R7: `topValid` is high when any enabled pending bit is set. `topIdx` then gives the highest such bit number. `topIdx` is 0 when `topValid` is low.
- R8: Bits 31:7 of both registers read as zero, and writing them has no effect. Any other offset reads zero, and a write to it changes nothing.
- R9: Writing 0 to offset 0x54 and then 0 to offset 0x50 leaves `irqReq` low and both registers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Register byte offset (used for both reads and writes) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| evtIn | input | 7 | Event lines; a high bit sets its pending bit |
| irqReq | output | 1 | Level request to the parent controller |
| topValid | output | 1 | Some enabled source is pending |
| topIdx | output | 3 | Highest enabled pending source number |

## Verification
A hardware event and a bus write to the pending register can fall in the same cycle. The bench provokes this in two ways. Directed steps raise an event bit while software writes that same bit to 0, and while it writes other bits to 1. A long random phase then drives events and writes to both registers freely. A behavioural reference model gives the event precedence bit by bit. The bench compares read data, the request and the top-source status against that model after every clock.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  // strobes from bus decode to the register datapath
  typedef struct packed {
    logic wrPend;
    logic wrEnab;
  } regStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PEND = 2'd1,
    RD_ENAB = 2'd2
  } rdSel_t;
endpackage

// File: rtl/pm_irq_ctrl.sv
module pm_irq_ctrl
  import pm_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PEND_OFS = 8'h50,
  parameter logic [ADDR_W-1:0] ENAB_OFS = 8'h54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);
  always_comb begin
    strobe.wrPend = busWrEn && (busAddr == PEND_OFS);
    strobe.wrEnab = busWrEn && (busAddr == ENAB_OFS);
    if (busAddr == PEND_OFS)      rdSel = RD_PEND;
    else if (busAddr == ENAB_OFS) rdSel = RD_ENAB;
    else                          rdSel = RD_NONE;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrPend, strobe.wrEnab})); // R8
  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrPend || strobe.wrEnab) |-> busWrEn); // R8
endmodule

// File: rtl/pm_irq_prio.sv
module pm_irq_prio #(
  parameter int NUM_SRC = 7,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] reqVec,
  output logic               anyReq,
  output logic [IDX_W-1:0]   highIdx
);
  // ascending scan: the last hit is the highest-numbered source
  always_comb begin
    anyReq  = 1'b0;
    highIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqVec[i]) begin
        anyReq  = 1'b1;
        highIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pm_irq_datapath.sv
module pm_irq_datapath
  import pm_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  rdSel_t             rdSel,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqReq,
  output logic               topValid,
  output logic [IDX_W-1:0]   topIdx
);
  logic [NUM_SRC-1:0] pendQ, pendD, enabQ, activeVec;

  // a software write is applied first, then events are ORed on top
  always_comb begin
    pendD = strobe.wrPend ? wrBits : pendQ;
    pendD = pendD | evtIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      enabQ <= '0;
    end else begin
      pendQ <= pendD;
      if (strobe.wrEnab) enabQ <= wrBits;
    end
  end

  assign activeVec = pendQ & enabQ;
  assign irqReq    = |activeVec;

  pm_irq_prio #(.NUM_SRC(NUM_SRC)) i_prio (
    .reqVec (activeVec),
    .anyReq (topValid),
    .highIdx(topIdx)
  );

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_PEND: rdData[NUM_SRC-1:0] = pendQ;
      RD_ENAB: rdData[NUM_SRC-1:0] = enabQ;
      default: rdData = '0;
    endcase
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((pendQ & $past(evtIn)) == $past(evtIn))); // R6
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrPend && evtIn == '0) |=> $stable(pendQ)); // R5
  AST_ENAB_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnab |=> (enabQ == $past(wrBits))); // R3
  AST_REQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == topValid); // R4
  AST_TOP_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rstN)
    topValid |-> ((activeVec >> topIdx) == NUM_SRC'(1))); // R7
  AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !topValid |-> (topIdx == '0)); // R7
endmodule

// File: rtl/pm_irq_aggregator.sv
module pm_irq_aggregator
  import pm_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] PEND_OFS = 8'h50,
  parameter logic [ADDR_W-1:0] ENAB_OFS = 8'h54,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic               irqReq,
  output logic               topValid,
  output logic [IDX_W-1:0]   topIdx
);
  regStrobe_t strobe;
  rdSel_t     rdSel;
  logic       unusedHighBits;

  // bits above the source count have no storage
  assign unusedHighBits = ^busWdata[DATA_W-1:NUM_SRC];

  pm_irq_ctrl #(
    .ADDR_W(ADDR_W), .PEND_OFS(PEND_OFS), .ENAB_OFS(ENAB_OFS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .strobe(strobe), .rdSel(rdSel)
  );

  pm_irq_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .wrBits(busWdata[NUM_SRC-1:0]), .evtIn(evtIn),
    .rdData(busRdata), .irqReq(irqReq),
    .topValid(topValid), .topIdx(topIdx)
  );
endmodule

// File: tb/test_pm_irq_aggregator.sv
`timescale 1ns/1ps
module test_pm_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [6:0]  evtIn = '0;
  logic        irqReq, topValid;
  logic [2:0]  topIdx;

  int compared = 0, mismatched = 0;
  int mPend = 0, mEnab = 0;
  string phase = "R1";
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  pm_irq_aggregator i_pm_irq_aggregator (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn),
    .irqReq(irqReq), .topValid(topValid), .topIdx(topIdx)
  );

  // behavioural reference: events take precedence over a same-cycle write
  always @(posedge clk) begin
    int np;
    if (!rstN) begin
      mPend = 0; mEnab = 0;
    end else begin
      np = mPend;
      if (busWrEn && busAddr == 8'h50) np = int'(busWdata) & 'h7F;
      np = np | int'(evtIn);
      if (busWrEn && busAddr == 8'h54) mEnab = int'(busWdata) & 'h7F;
      mPend = np;
    end
  end

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s (phase %s) actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int act = mPend & mEnab;
    int expRd = 0, expIdx = 0;
    if (busAddr == 8'h50) expRd = mPend;
    else if (busAddr == 8'h54) expRd = mEnab;
    for (int i = 0; i < 7; i++) if (act[i]) expIdx = i;
    chk(busAddr == 8'h50 ? "R2" : (busAddr == 8'h54 ? "R3" : "R8"), int'(busRdata), expRd);
    chk("R4", int'(irqReq), int'(act != 0));
    chk("R7", int'(topValid), int'(act != 0));
    chk("R7", int'(topIdx), expIdx);
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic drive(bit we, logic [7:0] a, logic [31:0] d, logic [6:0] e);
    busWrEn = we; busAddr = a; busWdata = d; evtIn = e;
    tick();
    busWrEn = 1'b0; evtIn = '0;
  endtask

  task automatic readAt(logic [7:0] a, int exp, string req);
    busAddr = a;
    tick();
    chk(req, int'(busRdata), exp);
  endtask

  initial begin
    phase = "R1";
    repeat (3) tick();
    chk("R1", int'(irqReq), 0);
    rstN = 1'b1;
    tick();
    readAt(8'h50, 0, "R1");
    readAt(8'h54, 0, "R1");
    chk("R1", int'(topValid), 0);

    phase = "R3"; drive(1, 8'h54, 32'h7F, '0); readAt(8'h54, 'h7F, "R3");
    phase = "R2"; drive(1, 8'h50, 32'h55, '0); readAt(8'h50, 'h55, "R2");
    chk("R4", int'(irqReq), 1);
    phase = "R7"; chk("R7", int'(topIdx), 6);
    drive(1, 8'h50, 32'h0A, '0); chk("R7", int'(topIdx), 3);
    drive(1, 8'h54, 32'h02, '0); chk("R7", int'(topIdx), 1);
    phase = "R4"; drive(1, 8'h54, 32'h04, '0); chk("R4", int'(irqReq), 0);
    phase = "R8";
    drive(1, 8'h50, 32'hFFFF_FF80, '0); readAt(8'h50, 0, "R8");
    drive(1, 8'h54, 32'hFFFF_FF81, '0); readAt(8'h54, 1, "R8");
    drive(1, 8'h58, 32'hFFFF_FFFF, '0); readAt(8'h58, 0, "R8");
    readAt(8'h50, 0, "R8"); readAt(8'h54, 1, "R8");
    phase = "R5";
    drive(1, 8'h54, 32'h7F, '0);
    drive(0, 8'h50, 0, 7'h10); readAt(8'h50, 'h10, "R5");
    repeat (3) tick(); chk("R5", int'(busRdata), 'h10);
    chk("R7", int'(topIdx), 4);
    phase = "R6";
    drive(1, 8'h50, 32'h00, 7'h04); readAt(8'h50, 'h04, "R6");
    drive(1, 8'h50, 32'h41, 7'h02); readAt(8'h50, 'h43, "R6");
    drive(1, 8'h50, 32'h7F, 7'h01); readAt(8'h50, 'h7F, "R6");
    phase = "RAND";
    for (int n = 0; n < 2000; n++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] a = (r < 4) ? 8'h50 : ((r < 7) ? 8'h54 : 8'h5C);
      drive($urandom_range(0, 2) != 0, a, $urandom(),
            ($urandom_range(0, 3) == 0) ? 7'($urandom()) : 7'h00);
    end
    phase = "R9";
    drive(1, 8'h54, 0, '0); drive(1, 8'h50, 0, '0);
    chk("R9", int'(irqReq), 0);
    readAt(8'h50, 0, "R9"); readAt(8'h54, 0, "R9");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired (phase %s)", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule